// File: doc/BRIEF.md
# Head Load and Initial Seek Sequencer

This block sequences a disk carriage from its parked home position out to track zero. It holds the carriage still while a retract request is present. A load-heads pulse then lets the carriage creep forward and the heads load. The beginning-of-track marker is detected next. Finally, on an odd detent pulse that arrives with the position difference at zero, the block hands control to detent (track-follow) mode.

All pulse and level inputs are asynchronous. Each passes through a two-stage synchronizer, and edges are detected in the block's clock domain. The cross-resetting flip-flop network is modelled as one four-state register. The retract request has priority over every other term and returns the block to the unload state from anywhere. Outputs decode from the state register, except the seek-accelerate trigger, which is a registered one-cycle pulse.

Top module: `head_seek_seq`

## Requirements
- R1: While `rst_n` is low, and after any retract, the outputs show the unload code: `fwd_inh`=1, `coarse_en`=0, `ld_sel`=1, `cntr_clr`=1, `fwd`=1, `det_en`=0.
- R2: A high `rtz` forces the unload state from any state. While `rtz` is high, no pulse input changes the state.
- R3: In the unload state, a rising edge of `load_pulse` moves the block to the load state. The load-state outputs are `fwd_inh`=0, `coarse_en`=0, `ld_sel`=1, `cntr_clr`=1, `fwd`=0, `det_en`=0.
- R4: `acc_trig` is high for exactly one clock cycle each time the block enters the load state from unload. Otherwise it is low.
- R5: In the load state, a rising edge of `bot_pulse` moves the block to the BOT-wait state, whose outputs equal the load-state outputs. A BOT rising edge in the unload state is ignored.
- R6: A falling edge of `bot_pulse` never changes the state.
- R7: In the BOT-wait state, a rising edge of `odd_det` while `diff_zero` is high enters detent. An odd detent edge with `diff_zero` low, or in any other state, is ignored.
- R8: Detent outputs are `fwd_inh`=0, `coarse_en`=1, `ld_sel`=0, `cntr_clr`=0, `fwd`=0, `det_en`=1. Detent is left only through `rtz`, and a load pulse there is ignored.
- R9: An input change made before a rising clock edge reaches the outputs on the third rising edge (two synchronizer stages plus the state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtz | input | 1 | Retract request, level |
| load_pulse | input | 1 | Load-heads pulse |
| bot_pulse | input | 1 | Beginning-of-track marker pulse |
| odd_det | input | 1 | Odd detent pulse |
| diff_zero | input | 1 | Position difference equals zero |
| fwd_inh | output | 1 | Forward inhibit to servo |
| coarse_en | output | 1 | Coarse servo enable |
| ld_sel | output | 1 | Load/unload drive select |
| cntr_clr | output | 1 | Cylinder counter clear, blocks detent counts |
| fwd | output | 1 | Forward direction select |
| acc_trig | output | 1 | Seek-accelerate trigger, one cycle |
| det_en | output | 1 | Detent enable |

## Verification
A wrong internal state shows at the ports within one cycle of the state register update. The exception is a confusion between the load state and the BOT-wait state, whose output codes match. That case shows only later: an odd detent pulse with `diff_zero` high either raises `det_en` when it should not, or fails to raise it when it should. The stimulus therefore drives a detent attempt after each BOT event, so the two hidden states can be told apart. A lost retract or a lost transition shows within three edges of the input change as a wrong six-bit output code.

// File: rtl/head_seek_seq.sv
module head_seek_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic rtz,
  input  logic load_pulse,
  input  logic bot_pulse,
  input  logic odd_det,
  input  logic diff_zero,
  output logic fwd_inh,
  output logic coarse_en,
  output logic ld_sel,
  output logic cntr_clr,
  output logic fwd,
  output logic acc_trig,
  output logic det_en
);

  typedef enum logic [1:0] {ST_UNLD, ST_LOAD, ST_BOT, ST_DET} st_t;

  localparam int NIN = 5;

  logic [NIN-1:0] s1, s2, s3;
  st_t st, st_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= {diff_zero, odd_det, bot_pulse, load_pulse, rtz};
      s2 <= s1;
      s3 <= s2;
    end

  wire rtz_s    = s2[0];
  wire ld_rise  = s2[1] & ~s3[1];
  wire bot_rise = s2[2] & ~s3[2];
  wire odd_rise = s2[3] & ~s3[3];
  wire dz_s     = s2[4];

  always_comb begin
    st_nx = st;
    if (rtz_s) st_nx = ST_UNLD;
    else
      case (st)
        ST_UNLD: if (ld_rise) st_nx = ST_LOAD;
        ST_LOAD: if (bot_rise) st_nx = ST_BOT;
        ST_BOT:  if (odd_rise && dz_s) st_nx = ST_DET;
        default: st_nx = st;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= ST_UNLD;
      acc_trig <= 1'b0;
    end else begin
      st       <= st_nx;
      acc_trig <= (st == ST_UNLD) && (st_nx == ST_LOAD);
    end

  assign fwd_inh   = (st == ST_UNLD);
  assign fwd       = (st == ST_UNLD);
  assign det_en    = (st == ST_DET);
  assign coarse_en = (st == ST_DET);
  assign ld_sel    = (st != ST_DET);
  assign cntr_clr  = (st != ST_DET);

  AST_RTZ_UNLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rtz_s |=> (fwd_inh && !det_en)); // R2

  AST_LOAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOAD && $past(st) != ST_LOAD) |-> $past(st) == ST_UNLD); // R3

  AST_ACC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_trig |=> !acc_trig); // R4

  AST_BOT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BOT && $past(st) != ST_BOT) |-> $past(st) == ST_LOAD); // R5

  AST_DET_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_en) |-> $past(dz_s && odd_rise && st == ST_BOT)); // R7

  AST_DET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && !rtz_s) |=> det_en); // R8

endmodule

// File: tb/sim_head_seek_seq.sv
`timescale 1ns/1ps
module sim_head_seek_seq;
  logic clk = 0, rst_n = 0;
  logic rtz = 0, load_pulse = 0, bot_pulse = 0, odd_det = 0, diff_zero = 0;
  logic fwd_inh, coarse_en, ld_sel, cntr_clr, fwd, acc_trig, det_en;
  int n_chk = 0, n_bad = 0, acc_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  head_seek_seq u0 (.clk, .rst_n, .rtz, .load_pulse, .bot_pulse, .odd_det,
    .diff_zero, .fwd_inh, .coarse_en, .ld_sel, .cntr_clr, .fwd, .acc_trig, .det_en);

  localparam logic [5:0] O_UNLD = 6'b101110;
  localparam logic [5:0] O_LOAD = 6'b001100;
  localparam logic [5:0] O_DET  = 6'b010001;

  // {rtz, load, bot, odd, dz, expected outputs}
  localparam logic [10:0] VEC [26] = '{
    {5'b10000, O_UNLD}, {5'b00000, O_UNLD}, {5'b00011, O_UNLD}, {5'b00000, O_UNLD},
    {5'b00100, O_UNLD}, {5'b00000, O_UNLD}, {5'b01000, O_LOAD}, {5'b00000, O_LOAD},
    {5'b00011, O_LOAD}, {5'b00000, O_LOAD}, {5'b00100, O_LOAD}, {5'b00000, O_LOAD},
    {5'b00010, O_LOAD}, {5'b00000, O_LOAD}, {5'b00001, O_LOAD}, {5'b00011, O_DET},
    {5'b00001, O_DET},  {5'b01001, O_DET},  {5'b00000, O_DET},  {5'b10000, O_UNLD},
    {5'b11000, O_UNLD}, {5'b00000, O_UNLD}, {5'b01000, O_LOAD}, {5'b00000, O_LOAD},
    {5'b10000, O_UNLD}, {5'b00000, O_UNLD}};

  function automatic logic [5:0] outs();
    return {fwd_inh, coarse_en, ld_sel, cntr_clr, fwd, det_en};
  endfunction

  task automatic chk(input logic [5:0] exp, input string req);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b", req, outs(), exp);
    end
  endtask

  task automatic drive(input logic [4:0] v);
    {rtz, load_pulse, bot_pulse, odd_det, diff_zero} = v;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) if (acc_trig) acc_cnt++;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(O_UNLD, "R1 reset");
    rst_n = 1;
    @(negedge clk);

    // Table walk: R2 R3 R5 R7 R8
    for (int i = 0; i < 26; i++) begin
      drive(VEC[i][10:6]);
      settle();
      chk(VEC[i][5:0], $sformatf("R2/R3/R5/R7/R8 vector %0d", i));
    end
    n_chk++;
    if (acc_cnt != 2) begin
      n_bad++;
      $display("FAIL R4: acc_trig cycles %0d expected 2", acc_cnt);
    end

    // R9 latency: load rise visible on the third edge
    drive(5'b00000); settle();
    load_pulse = 1;
    repeat (2) @(posedge clk); @(negedge clk);
    chk(O_UNLD, "R9 before third edge");
    @(posedge clk); @(negedge clk);
    chk(O_LOAD, "R9 third edge");
    load_pulse = 0; settle();

    // R2 retract from BOT-wait, then detent attempt must fail
    bot_pulse = 1; settle(); bot_pulse = 0; settle();
    rtz = 1; settle(); rtz = 0; settle();
    chk(O_UNLD, "R2 retract from BOT-wait");
    diff_zero = 1; odd_det = 1; settle(); odd_det = 0; diff_zero = 0; settle();
    chk(O_UNLD, "R2 no detent after retract");

    // R6: BOT falling edge in load does not advance
    bot_pulse = 1; settle();
    acc_cnt = 0;
    load_pulse = 1; settle(); load_pulse = 0; settle();
    n_chk++;
    if (acc_cnt != 1) begin
      n_bad++;
      $display("FAIL R4: acc_trig cycles %0d expected 1", acc_cnt);
    end
    bot_pulse = 0; settle();
    chk(O_LOAD, "R6 falling BOT");
    diff_zero = 1; odd_det = 1; settle();
    chk(O_LOAD, "R6 still load, odd ignored (R7)");
    odd_det = 0; settle();
    bot_pulse = 1; settle(); bot_pulse = 0;
    odd_det = 1; settle();
    chk(O_DET, "R7 detent after real BOT");
    odd_det = 0; diff_zero = 0; settle();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule